// File: doc/BRIEF.md
# Dual Multi-Mode Timer/Counter

This block provides two timer/counter channels, each built from a low byte and a high byte. A channel advances on a shared machine-cycle enable (`tick`), or, when set up as an event counter, on falling edges of its own count pin, which is sampled once per tick. Each channel is set up through a shared mode register and a shared control register, and its count bytes can be read and written, all through a plain single-cycle register port. Each channel has four counting layouts: a 13-bit count with a 5-bit prescaler, a plain 16-bit count, an 8-bit count that reloads itself from the high byte, and a split layout.

In the split layout, channel 0 runs as two independent 8-bit counters. The upper counter borrows channel 1's run bit and overflow flag. While channel 0 is split, channel 1 keeps counting, and its overflow only drives the baud-rate pulse. Counting can be gated by the level on the matching external interrupt pin. Overflow flags and external-interrupt flags are brought out as interrupt requests. An interrupt controller clears them with acknowledge strobes.

The block has no streaming data path. Every pin is a plain control or status level, or a single-cycle strobe, so there is no back-pressure.

Top module: `tmr_dual`

## Requirements
- R1: After reset, every register (address 0..5) reads 0x00, and `irq_tmr`, `irq_ext` and `baud_pulse` are 0.
- R2: Register map. Address 0 is the mode register: bits 3..0 are channel 0's {gate, event-count, mode[1:0]} and bits 7..4 are the same fields for channel 1. Address 1 is the control register: {ovf1, run1, ovf0, run0, ext1, type1, ext0, type0}, with bit 7 first. Addresses 2 and 3 are channel 0's low and high bytes; addresses 4 and 5 are channel 1's low and high bytes. A register write takes priority over any hardware update of the same register in that cycle.
- R3: With gate=0 and event-count=0, a channel advances by one on each `tick` while its run bit is 1. It does not advance while its run bit is 0.
- R4: With gate=1, the channel advances only while the matching `xint_pin` is high.
- R5: With event-count=1, the channel advances by one at a tick where the previous tick's sample of its `cnt_pin` was 1 and the current value is 0. It does not advance on any other tick.
- R6: Mode 1 (16-bit): a rollover from 0xFFFF to 0x0000 sets the channel's overflow flag.
- R7: Mode 0 (13-bit): the low 5 bits of the low byte act as a prescaler for the high byte. The upper 3 bits of the low byte keep their value. A rollover of all 13 bits sets the overflow flag.
- R8: Mode 2: the low byte counts. On its rollover it loads the high byte and sets the overflow flag, and the high byte is left unchanged.
- R9: Mode 3 on channel 0: the low byte counts under channel 0's controls and overflow flag. The high byte counts ticks while run1=1, and its rollover sets ovf1. Channel 1 then counts as if run1 were 1, and does not set ovf1.
- R10: Mode 3 on channel 1 holds its count.
- R11: `ack_tmr[c]` clears overflow flag c. A flag being set in the same cycle wins over the acknowledge.
- R12: When type=1, an external flag is set by a falling edge on `xint_pin`, sampled at ticks, and cleared by `ack_ext`. When type=0, the flag follows the inverted pin level at each tick, and `ack_ext` has no effect.
- R13: Each channel 1 overflow produces a one-cycle `baud_pulse`, in the cycle right after the tick that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Machine-cycle enable |
| cnt_pin | input | 2 | Event-count inputs, one per channel |
| xint_pin | input | 2 | External interrupt and gate pins, one per channel |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| ack_tmr | input | 2 | Overflow-flag acknowledge strobes |
| ack_ext | input | 2 | External-flag acknowledge strobes |
| irq_tmr | output | 2 | Overflow flags |
| irq_ext | output | 2 | External-interrupt flags |
| baud_pulse | output | 1 | One-cycle pulse for each channel 1 overflow |

## Verification
The bench builds the block with its default parameters: 8-bit bytes and a 5-bit prescaler. Because the count bytes are writable, each rollover point is reached by preloading a value a few ticks short of it. This covers the 13-bit wrap, the prescaler carry, the 8-bit reload and the 16-bit wrap in a handful of cycles each. The split layout, channel 1's hold, edge counting, gating and both external-flag types are driven in directed sequences.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [1:0] {
    MD_13    = 2'd0,
    MD_16    = 2'd1,
    MD_8R    = 2'd2,
    MD_SPLIT = 2'd3
  } tmr_mode_e;

  typedef enum logic [ADDR_W-1:0] {
    A_MODE = 3'd0,
    A_CTRL = 3'd1,
    A_LO0  = 3'd2,
    A_HI0  = 3'd3,
    A_LO1  = 3'd4,
    A_HI1  = 3'd5
  } tmr_addr_e;
endpackage

// File: rtl/tmr_pin_edge.sv
// Samples a pin once per tick and flags a high-to-low change between samples.
module tmr_pin_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic fall
);
  logic last_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    last_q <= 1'b1;
    else if (tick) last_q <= pin;
  end

  assign fall = tick & last_q & ~pin;
endmodule

// File: rtl/tmr_extint.sv
// One external interrupt flag: edge-set with acknowledge, or level-following.
module tmr_extint (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  input  logic fall,
  input  logic edge_mode,
  input  logic ack,
  input  logic wr,
  input  logic wbit,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)         flag <= 1'b0;
    else if (wr)        flag <= wbit;
    else if (edge_mode) begin
      if (fall)         flag <= 1'b1;
      else if (ack)     flag <= 1'b0;
    end
    else if (tick)      flag <= ~pin;
  end
endmodule

// File: rtl/tmr_chan.sv
// One channel's count bytes and the next-value logic for its four layouts.
module tmr_chan
  import tmr_pkg::*;
#(
  parameter int DW    = 8,
  parameter int PW    = 5,
  parameter bit SPLIT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  tmr_mode_e     mode,
  input  logic          inc,
  input  logic          inc_hi,
  input  logic          wr_lo,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] lo,
  output logic [DW-1:0] hi,
  output logic          ovf,
  output logic          ovf_hi
);
  logic [DW-1:0] nlo, nhi;
  logic [DW-1:0] sp_lo, sp_hi;
  logic          sp_ovf, sp_ovf_hi;

  generate
    if (SPLIT) begin : g_split
      always_comb begin
        sp_lo     = inc    ? lo + 1'b1 : lo;
        sp_hi     = inc_hi ? hi + 1'b1 : hi;
        sp_ovf    = inc    & (&lo);
        sp_ovf_hi = inc_hi & (&hi);
      end
    end else begin : g_hold
      always_comb begin
        sp_lo     = lo;
        sp_hi     = hi;
        sp_ovf    = 1'b0;
        sp_ovf_hi = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    nlo    = lo;
    nhi    = hi;
    ovf    = 1'b0;
    ovf_hi = 1'b0;
    unique case (mode)
      MD_13: if (inc) begin
        if (&lo[PW-1:0]) begin
          nlo[PW-1:0] = '0;
          nhi         = hi + 1'b1;
          ovf         = &hi;
        end else begin
          nlo[PW-1:0] = lo[PW-1:0] + 1'b1;
        end
      end
      MD_16: if (inc) begin
        {nhi, nlo} = {hi, lo} + 1'b1;
        ovf        = &{hi, lo};
      end
      MD_8R: if (inc) begin
        if (&lo) begin
          nlo = hi;
          ovf = 1'b1;
        end else begin
          nlo = lo + 1'b1;
        end
      end
      MD_SPLIT: begin
        nlo    = sp_lo;
        nhi    = sp_hi;
        ovf    = sp_ovf;
        ovf_hi = sp_ovf_hi;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo <= '0;
      hi <= '0;
    end else begin
      lo <= wr_lo ? wdata : nlo;
      hi <= wr_hi ? wdata : nhi;
    end
  end
endmodule

// File: rtl/tmr_dual.sv
module tmr_dual
  import tmr_pkg::*;
#(
  parameter int DW = BYTE_W,
  parameter int PW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        cnt_pin,
  input  logic [1:0]        xint_pin,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [1:0]        ack_tmr,
  input  logic [1:0]        ack_ext,
  output logic [1:0]        irq_tmr,
  output logic [1:0]        irq_ext,
  output logic              baud_pulse
);
  localparam int NCH = 2;

  logic [DW-1:0]  mode_q;
  logic [NCH-1:0] tr_q, it_q, tf_q, ie_q, tf_set;
  logic [NCH-1:0] c_fall, x_fall, gate_ok, pulse;
  logic [DW-1:0]  lo0, hi0, lo1, hi1;
  logic           ovf0, ovf0_hi, ovf1, ovf1_hi;
  logic           split_on, inc0, inc1, inc0_hi;
  logic           wr_mode, wr_ctrl;

  assign wr_mode = reg_we && (reg_addr == A_MODE);
  assign wr_ctrl = reg_we && (reg_addr == A_CTRL);

  // Per-channel pin sampling, gating and external flags.
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tmr_pin_edge u_cnt_edge (
      .clk(clk), .rst_n(rst_n), .tick(tick), .pin(cnt_pin[c]), .fall(c_fall[c])
    );
    tmr_pin_edge u_x_edge (
      .clk(clk), .rst_n(rst_n), .tick(tick), .pin(xint_pin[c]), .fall(x_fall[c])
    );
    tmr_extint u_ext (
      .clk(clk), .rst_n(rst_n), .tick(tick), .pin(xint_pin[c]), .fall(x_fall[c]),
      .edge_mode(it_q[c]), .ack(ack_ext[c]), .wr(wr_ctrl),
      .wbit(reg_wdata[2*c+1]), .flag(ie_q[c])
    );
    assign gate_ok[c] = ~mode_q[4*c+3] | xint_pin[c];
    assign pulse[c]   = mode_q[4*c+2] ? c_fall[c] : tick;
  end

  assign split_on = (tmr_mode_e'(mode_q[1:0]) == MD_SPLIT);
  assign inc0     = tr_q[0] & gate_ok[0] & pulse[0];
  assign inc1     = (split_on | tr_q[1]) & gate_ok[1] & pulse[1];
  assign inc0_hi  = split_on & tick & tr_q[1];

  tmr_chan #(.DW(DW), .PW(PW), .SPLIT(1'b1)) u_ch0 (
    .clk(clk), .rst_n(rst_n), .mode(tmr_mode_e'(mode_q[1:0])),
    .inc(inc0), .inc_hi(inc0_hi),
    .wr_lo(reg_we && reg_addr == A_LO0), .wr_hi(reg_we && reg_addr == A_HI0),
    .wdata(reg_wdata), .lo(lo0), .hi(hi0), .ovf(ovf0), .ovf_hi(ovf0_hi)
  );

  tmr_chan #(.DW(DW), .PW(PW), .SPLIT(1'b0)) u_ch1 (
    .clk(clk), .rst_n(rst_n), .mode(tmr_mode_e'(mode_q[5:4])),
    .inc(inc1), .inc_hi(1'b0),
    .wr_lo(reg_we && reg_addr == A_LO1), .wr_hi(reg_we && reg_addr == A_HI1),
    .wdata(reg_wdata), .lo(lo1), .hi(hi1), .ovf(ovf1), .ovf_hi(ovf1_hi)
  );

  assign tf_set[0] = ovf0;
  assign tf_set[1] = split_on ? ovf0_hi : ovf1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= '0;
      tr_q       <= '0;
      it_q       <= '0;
      tf_q       <= '0;
      baud_pulse <= 1'b0;
    end else begin
      baud_pulse <= ovf1;
      if (wr_mode) mode_q <= reg_wdata;
      if (wr_ctrl) begin
        tf_q <= {reg_wdata[7], reg_wdata[5]};
        tr_q <= {reg_wdata[6], reg_wdata[4]};
        it_q <= {reg_wdata[2], reg_wdata[0]};
      end else begin
        for (int c = 0; c < NCH; c++) begin
          if (tf_set[c])       tf_q[c] <= 1'b1;
          else if (ack_tmr[c]) tf_q[c] <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    unique case (reg_addr)
      A_MODE:  reg_rdata = mode_q;
      A_CTRL:  reg_rdata = {tf_q[1], tr_q[1], tf_q[0], tr_q[0],
                            ie_q[1], it_q[1], ie_q[0], it_q[0]};
      A_LO0:   reg_rdata = lo0;
      A_HI0:   reg_rdata = hi0;
      A_LO1:   reg_rdata = lo1;
      A_HI1:   reg_rdata = hi1;
      default: reg_rdata = '0;
    endcase
  end

  assign irq_tmr = tf_q;
  assign irq_ext = ie_q;
endmodule

// File: rtl/tmr_dual_chk.sv
module tmr_dual_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          reg_we,
  input logic [2:0]    reg_addr,
  input logic [1:0]    xint_pin,
  input logic [1:0]    ack_tmr,
  input logic [1:0]    ack_ext,
  input logic [1:0]    irq_tmr,
  input logic [1:0]    irq_ext,
  input logic          baud_pulse,
  input logic [DW-1:0] mode_q,
  input logic [1:0]    tr_q,
  input logic [1:0]    it_q,
  input logic [1:0]    tf_set,
  input logic [1:0]    x_fall,
  input logic          ovf0,
  input logic [DW-1:0] lo0,
  input logic [DW-1:0] hi0,
  input logic [DW-1:0] lo1,
  input logic [DW-1:0] hi1
);
  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode_q[3:0] == 4'b0001 && tr_q[0] && !reg_we)
      |=> ({hi0, lo0} == $past({hi0, lo0}) + 1'b1));

  assert_gate_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[3] && !xint_pin[0] && mode_q[1:0] != 2'd3 && !reg_we)
      |=> ($stable(lo0) && $stable(hi0)));

  assert_reload_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf0 && mode_q[1:0] == 2'd2 && !reg_we) |=> (lo0 == $past(hi0)));

  assert_hold_ch1_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[5:4] == 2'd3 && !(reg_we && (reg_addr == 3'd4 || reg_addr == 3'd5)))
      |=> ($stable(lo1) && $stable(hi1)));

  assert_ack_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_tmr[0] && !tf_set[0] && !reg_we) |=> !irq_tmr[0]);

  assert_edge_ack_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (it_q[0] && ack_ext[0] && !x_fall[0] && !reg_we) |=> !irq_ext[0]);

  assert_baud_tick_R13: assert property (@(posedge clk) disable iff (!rst_n)
    baud_pulse |-> $past(tick));
endmodule

bind tmr_dual tmr_dual_chk #(.DW(DW)) u_chk (.*);

// File: tb/tmr_dual_bench.sv
module tmr_dual_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic [1:0] cnt_pin = 2'b11;
  logic [1:0] xint_pin = 2'b11;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [1:0] ack_tmr = 2'b00;
  logic [1:0] ack_ext = 2'b00;
  logic [1:0] irq_tmr, irq_ext;
  logic       baud_pulse;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  tmr_dual u_tmr_dual (.*);

  typedef struct packed {
    logic [7:0] md, ct, lo, hi;
    logic       xp;
    logic [3:0] n;
    logic [7:0] elo, ehi, ectl;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t TBL [NV] = '{
    '{8'h01, 8'h10, 8'hFE, 8'hFF, 1'b1, 4'd3, 8'h01, 8'h00, 8'h30}, // R6 16-bit wrap
    '{8'h00, 8'h10, 8'hFE, 8'h05, 1'b1, 4'd3, 8'hE1, 8'h06, 8'h10}, // R7 prescaler carry
    '{8'h00, 8'h10, 8'h1F, 8'hFF, 1'b1, 4'd1, 8'h00, 8'h00, 8'h30}, // R7 13-bit wrap
    '{8'h02, 8'h10, 8'hFE, 8'h80, 1'b1, 4'd3, 8'h81, 8'h80, 8'h30}, // R8 reload
    '{8'h01, 8'h00, 8'h12, 8'h34, 1'b1, 4'd5, 8'h12, 8'h34, 8'h00}, // R3 run off
    '{8'h09, 8'h10, 8'h40, 8'h00, 1'b0, 4'd4, 8'h40, 8'h00, 8'h12}, // R4 gate low
    '{8'h09, 8'h10, 8'h40, 8'h00, 1'b1, 4'd4, 8'h44, 8'h00, 8'h10}, // R4 gate high
    '{8'h02, 8'h10, 8'hFF, 8'hF0, 1'b1, 4'd2, 8'hF1, 8'hF0, 8'h30}  // R8 reload
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic summary;
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5ns * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v); check("R1 reg", v, 8'h00);
    end
    check("R1 irq", {3'b0, baud_pulse, irq_tmr, irq_ext}, 8'h00);

    // R2 readback of mode register
    wr(3'd0, 8'hA5); rd(3'd0, v); check("R2 mode", v, 8'hA5);

    // Table of channel 0 cases
    for (int i = 0; i < NV; i++) begin
      wr(3'd1, 8'h00);
      xint_pin[0] = TBL[i].xp;
      wr(3'd0, TBL[i].md);
      wr(3'd2, TBL[i].lo);
      wr(3'd3, TBL[i].hi);
      wr(3'd1, TBL[i].ct);
      ticks(int'(TBL[i].n));
      rd(3'd2, v); check($sformatf("R3-vec%0d lo", i), v, TBL[i].elo);
      rd(3'd3, v); check($sformatf("R3-vec%0d hi", i), v, TBL[i].ehi);
      rd(3'd1, v); check($sformatf("R6-vec%0d ctrl", i), v, TBL[i].ectl);
      xint_pin[0] = 1'b1;
    end

    // R5 event counting on falling edges
    wr(3'd1, 8'h00); wr(3'd0, 8'h05); wr(3'd2, 8'h00); wr(3'd3, 8'h00);
    wr(3'd1, 8'h10);
    cnt_pin[0] = 1'b1; ticks(1);
    cnt_pin[0] = 1'b0; ticks(2);
    cnt_pin[0] = 1'b1; ticks(1);
    cnt_pin[0] = 1'b0; ticks(1);
    rd(3'd2, v); check("R5 edges", v, 8'h02);
    cnt_pin[0] = 1'b1;

    // R9 split layout on channel 0
    wr(3'd1, 8'h00); wr(3'd0, 8'h13);
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd4, 8'h00); wr(3'd5, 8'h00);
    wr(3'd1, 8'h50);
    ticks(1);
    rd(3'd2, v); check("R9 lo0", v, 8'h00);
    rd(3'd3, v); check("R9 hi0", v, 8'h00);
    rd(3'd4, v); check("R9 ch1 free run", v, 8'h01);
    rd(3'd1, v); check("R9 ctrl", v, 8'hF0);
    check("R9 irq", {6'b0, irq_tmr}, 8'h03);

    // R11 acknowledge clears overflow flags
    @(negedge clk) ack_tmr = 2'b11;
    @(negedge clk) ack_tmr = 2'b00;
    rd(3'd1, v); check("R11 ack", v, 8'h50);

    // R10 channel 1 holds in mode 3
    wr(3'd1, 8'h00); wr(3'd0, 8'h31); wr(3'd4, 8'hAA); wr(3'd5, 8'h55);
    wr(3'd1, 8'h40);
    ticks(4);
    rd(3'd4, v); check("R10 lo1", v, 8'hAA);
    rd(3'd5, v); check("R10 hi1", v, 8'h55);

    // R13 baud pulse from channel 1 reload overflow
    wr(3'd1, 8'h00); wr(3'd0, 8'h21); wr(3'd5, 8'hFD); wr(3'd4, 8'hFE);
    wr(3'd1, 8'h40);
    ticks(1);
    check("R13 no pulse", {7'b0, baud_pulse}, 8'h00);
    ticks(1);
    check("R13 pulse", {7'b0, baud_pulse}, 8'h01);
    @(negedge clk);
    check("R13 one cycle", {7'b0, baud_pulse}, 8'h00);
    rd(3'd4, v); check("R13 lo1 reload", v, 8'hFD);
    rd(3'd1, v); check("R13 ctrl ovf1", v, 8'hC0);

    // R12 edge-type external flag
    wr(3'd1, 8'h01);
    xint_pin[0] = 1'b1; ticks(1);
    xint_pin[0] = 1'b0; ticks(1);
    rd(3'd1, v); check("R12 edge set", v, 8'h03);
    @(negedge clk) ack_ext = 2'b01;
    @(negedge clk) ack_ext = 2'b00;
    rd(3'd1, v); check("R12 edge ack", v, 8'h01);
    xint_pin[0] = 1'b1; ticks(1);

    // R12 level-type external flag, acknowledge ignored
    wr(3'd1, 8'h00);
    xint_pin[0] = 1'b0; ticks(1);
    rd(3'd1, v); check("R12 level set", v, 8'h02);
    @(negedge clk) ack_ext = 2'b01;
    @(negedge clk) ack_ext = 2'b00;
    rd(3'd1, v); check("R12 level ack ignored", v, 8'h02);
    xint_pin[0] = 1'b1; ticks(1);
    rd(3'd1, v); check("R12 level clear", v, 8'h00);

    summary();
  end
endmodule